// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the instruction fetch unit and steers the program counter for hardware loops, so that a loop costs no branch instruction and no lost fetch cycle. It keeps two nested block-repeat levels. Each level has a start address, an end address and an iteration counter. When a valid fetch lands on the end address of an active level and its counter is nonzero, the block raises a redirect in the same cycle, gives the start address as the target, and decrements the counter. When the counter is already zero, the fetch falls through. The outer level then deactivates. The inner level reloads its saved count for the next outer pass, so an inner loop repeats in full on every outer iteration.

A single-instruction repeat is loaded with N−1 and makes the next fetched instruction issue N times. It does this by asking the fetch unit to hold the program counter (stall) for N−1 cycles. A block end is only evaluated on the final copy of a repeated instruction. A flush input, driven by the branch logic, aborts every loop and every pending repeat.

Software-visible loading goes through a single command port. An opcode selects which register is written, and writing a level's count arms that level.

Each level runs a two-state machine. LV_IDLE goes to LV_LOOP on a count load ("arm"). LV_LOOP stays in LV_LOOP on a redirect ("take"). LV_LOOP goes back to LV_IDLE on fall-through, on an outer finish ("kill") or on flush. An inner level instead stays in LV_LOOP with a reloaded count ("rearm") while the outer level carries on.

The repeat unit runs a three-state machine. RP_IDLE goes to RP_WAIT on a repeat load ("arm"). RP_WAIT goes to RP_RUN when a fetch arrives with a nonzero count ("hold"). RP_WAIT goes to RP_IDLE when a fetch arrives with a zero count ("single"). RP_RUN goes to RP_IDLE after the last stall ("release"). Flush sends either machine to its idle state.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, redirect_valid, stall, in_loop and both level_active bits are 0.
- R2: A command is accepted when cmd_valid is 1. Its cmd_op selects the action: 0 loads level 0 start, 1 loads level 0 end, 2 loads level 0 count and arms it, 3 loads level 1 start, 4 loads level 1 end, 5 loads level 1 count and arms it, 6 loads the single repeat count, and 7 does nothing. Addresses use all 24 bits of cmd_data and counts use its low CNT_W bits. Arming sets level_active[n] from the next cycle on. Start and end loads alone arm nothing.
- R3: When a valid fetch address equals an active level's end address and that level's counter is nonzero, redirect_valid is 1 in that same cycle, redirect_addr is that level's start address, and the counter decrements. A block armed with count C therefore runs C+1 times.
- R4: When the counter is zero at the end address, there is no redirect and fetch proceeds sequentially. Level 0 then leaves the loop.
- R5: A fetch whose address differs from every active end address never redirects and leaves the levels active.
- R6: Level 1 (inner) takes priority over level 0 when both end addresses match and level 1 redirects. In that case level 0's counter is untouched. If level 1 falls through on a shared end address, level 0 is evaluated in the same cycle.
- R7: When level 1 falls through while level 0 stays in its loop, level 1 reloads its armed count and remains active. When level 0 finishes, level 1 is cleared too.
- R8: A repeat count of N−1 makes the next valid fetch address issue N times, with stall at 1 for exactly N−1 consecutive cycles. A count of 0 gives no stall.
- R9: For a repeated instruction, a block-end match is evaluated only on its last issue. redirect_valid and stall are never 1 together.
- R10: flush clears both levels and any pending or running repeat from the next cycle on. It wins over a command in the same cycle.
- R11: in_loop is 1 exactly when a level is active or a repeat is pending or running.
- R12: With fetch_valid at 0, there is no redirect and no counter changes, even if fetch_addr equals an end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Abort all loops and repeats |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_data | input | 24 | Address or count payload |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 24 | Current fetch address |
| redirect_valid | output | 1 | Fetch must jump to redirect_addr next |
| redirect_addr | output | 24 | Loop start address target |
| stall | output | 1 | Hold the program counter next cycle |
| in_loop | output | 1 | Any loop or repeat in progress |
| level_active | output | 2 | Per-level active flags (bit 1 = inner) |

## Verification
Redirect and stall are combinational from the fetch address and the loop state. They are due in the same cycle as the fetch, so the bench drives each fetch at a falling edge and samples one nanosecond later. Counter decrements, arming, rearming and flush act at the next rising edge. Those effects are therefore checked at the following falling edge, either directly through level_active and in_loop or through the redirect pattern of the later fetches. A small fetch model follows redirects and stalls the way a real fetch unit would. Each loop scenario is then scored by how often given addresses are visited, how many redirects and stall cycles occur, and where the first redirect went.

// File: rtl/zol_pkg.sv
package zol_pkg;

    // Command opcodes; levels use a stride of three (start, end, count).
    typedef enum logic [2:0] {
        OP_START0 = 3'd0,
        OP_END0   = 3'd1,
        OP_COUNT0 = 3'd2,
        OP_START1 = 3'd3,
        OP_END1   = 3'd4,
        OP_COUNT1 = 3'd5,
        OP_RPT    = 3'd6,
        OP_NONE   = 3'd7
    } zol_op_e;

    typedef enum logic {
        LV_IDLE,
        LV_LOOP
    } lv_state_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_WAIT,
        RP_RUN
    } rp_state_e;

endpackage

// File: rtl/zol_level.sv
module zol_level
    import zol_pkg::*;
#(
    parameter int AW    = 24,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          ld_start,
    input  logic          ld_end,
    input  logic          ld_count,
    input  logic [AW-1:0] ld_data,
    input  logic          probe,
    input  logic [AW-1:0] addr,
    input  logic          grant,
    input  logic          nest_hold,
    input  logic          kill,
    output logic          take,
    output logic          fall,
    output logic [AW-1:0] start_addr,
    output logic          active
);

    lv_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   reload_q;
    logic [AW-1:0]   start_q;
    logic [AW-1:0]   end_q;
    logic            hit;

    // Address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            end_q    <= '0;
            reload_q <= '0;
        end else begin
            if (ld_start) start_q  <= ld_data;
            if (ld_end)   end_q    <= ld_data;
            if (ld_count) reload_q <= ld_data[CW-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (flush) begin
            state_d = LV_IDLE;
        end else if (ld_count) begin
            state_d = LV_LOOP;                     // arm
            cnt_d   = ld_data[CW-1:0];
        end else begin
            unique case (state_q)
                LV_IDLE: ;
                LV_LOOP: begin
                    if (kill) begin
                        state_d = LV_IDLE;         // kill
                    end else if (grant && take) begin
                        cnt_d = cnt_q - 1'b1;      // take
                    end else if (grant && fall) begin
                        if (nest_hold) cnt_d = reload_q;  // rearm
                        else           state_d = LV_IDLE; // fall through
                    end
                end
                default: state_d = LV_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hit        = (state_q == LV_LOOP) && probe && (addr == end_q);
        take       = hit && (cnt_q != '0);
        fall       = hit && (cnt_q == '0);
        start_addr = start_q;
        active     = (state_q == LV_LOOP);
    end

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && take && !flush && !ld_count && !kill) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r4_fall_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && fall && !nest_hold && !flush && !ld_count) |=> !active);

    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && fall && nest_hold && !kill && !flush && !ld_count) |=> (active && cnt_q == $past(reload_q)));

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_count && !flush) |=> active);

endmodule

// File: rtl/zol_repeat.sv
module zol_repeat
    import zol_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          ld,
    input  logic [CW-1:0] ld_count,
    input  logic          fetch_valid,
    output logic          stall,
    output logic          final_copy,
    output logic          busy
);

    rp_state_e     state_q, state_d;
    logic [CW-1:0] pend_q, pend_d;
    logic [CW-1:0] rem_q, rem_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            pend_q  <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            rem_q   <= rem_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        rem_d   = rem_q;
        if (flush) begin
            state_d = RP_IDLE;
        end else if (ld) begin
            state_d = RP_WAIT;                      // arm
            pend_d  = ld_count;
        end else begin
            unique case (state_q)
                RP_IDLE: ;
                RP_WAIT: begin
                    if (fetch_valid) begin
                        if (pend_q == '0) begin
                            state_d = RP_IDLE;      // single
                        end else begin
                            state_d = RP_RUN;       // hold
                            rem_d   = pend_q;
                        end
                    end
                end
                RP_RUN: begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == CW'(1)) state_d = RP_IDLE;  // release
                end
                default: state_d = RP_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        stall      = ((state_q == RP_WAIT) && fetch_valid && (pend_q != '0)) ||
                     ((state_q == RP_RUN) && (rem_q != CW'(1)));
        final_copy = (state_q == RP_IDLE) ||
                     ((state_q == RP_WAIT) && (pend_q == '0)) ||
                     ((state_q == RP_RUN) && (rem_q == CW'(1)));
        busy       = (state_q != RP_IDLE);
    end

    a_r8_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_RUN) |-> (rem_q != '0));

    a_r8_stall_continues: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RP_RUN) && stall && !flush && !ld) |=> (state_q == RP_RUN));

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_data,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr,
    output logic          stall,
    output logic          in_loop,
    output logic [1:0]    level_active
);

    localparam int LEVELS = 2;
    localparam int STRIDE = 3;

    logic [LEVELS-1:0] take, fall, active, grant, hold, kill;
    logic [AW-1:0]     lv_start [LEVELS];
    logic              rpt_ld, rpt_final, rpt_busy, probe;

    assign rpt_ld = cmd_valid && (cmd_op == OP_RPT);
    assign probe  = fetch_valid && rpt_final;

    zol_repeat #(.CW(CW)) u_rpt (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .ld          (rpt_ld),
        .ld_count    (cmd_data[CW-1:0]),
        .fetch_valid (fetch_valid),
        .stall       (stall),
        .final_copy  (rpt_final),
        .busy        (rpt_busy)
    );

    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        logic ld_s, ld_e, ld_c;
        assign ld_s = cmd_valid && (cmd_op == 3'(int'(OP_START0) + STRIDE*i));
        assign ld_e = cmd_valid && (cmd_op == 3'(int'(OP_END0)   + STRIDE*i));
        assign ld_c = cmd_valid && (cmd_op == 3'(int'(OP_COUNT0) + STRIDE*i));

        // Innermost level always wins; outer ones only when no inner redirect.
        if (i == LEVELS-1) begin : g_top
            assign grant[i] = 1'b1;
        end else begin : g_sub
            assign grant[i] = !take[i+1];
        end

        // Inner levels rearm while the enclosing level keeps looping.
        if (i == 0) begin : g_outer
            assign hold[i] = 1'b0;
            assign kill[i] = 1'b0;
        end else begin : g_inner
            assign kill[i] = grant[i-1] && fall[i-1];
            assign hold[i] = active[i-1] && !kill[i];
        end

        zol_level #(.AW(AW), .CW(CW)) u_lvl (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .ld_start   (ld_s),
            .ld_end     (ld_e),
            .ld_count   (ld_c),
            .ld_data    (cmd_data),
            .probe      (probe),
            .addr       (fetch_addr),
            .grant      (grant[i]),
            .nest_hold  (hold[i]),
            .kill       (kill[i]),
            .take       (take[i]),
            .fall       (fall[i]),
            .start_addr (lv_start[i]),
            .active     (active[i])
        );
    end

    always_comb begin
        redirect_valid = take[1] || (take[0] && grant[0]);
        redirect_addr  = take[1] ? lv_start[1] : lv_start[0];
        in_loop        = (|active) || rpt_busy;
        level_active   = active;
    end

    a_r9_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !stall);

    a_r12_idle_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !redirect_valid);

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!in_loop && level_active == 2'b00));

    a_r6_outer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (take[1] && active[0] && !flush && !cmd_valid) |=> active[0]);

endmodule

// File: tb/zol_ctrl_bench.sv
module zol_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd7;
    logic [23:0] cmd_data = '0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        redirect_valid;
    logic [23:0] redirect_addr;
    logic        stall;
    logic        in_loop;
    logic [1:0]  level_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int vis_a, vis_b, n_redir, n_stall, n_clash;
    logic [23:0] first_tgt;

    always #5 clk = ~clk;

    zol_ctrl u_zol_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_data       (cmd_data),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr),
        .stall          (stall),
        .in_loop        (in_loop),
        .level_active   (level_active)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [23:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Fetch model: follows redirects, holds on stall, else steps by one.
    task automatic run_fetch(input logic [23:0] pc0, input logic [23:0] stop,
                             input logic [23:0] wa, input logic [23:0] wb, input int maxc);
        logic [23:0] pc;
        pc = pc0; vis_a = 0; vis_b = 0; n_redir = 0; n_stall = 0; n_clash = 0; first_tgt = '0;
        for (int c = 0; c < maxc && pc != stop; c++) begin
            @(negedge clk);
            fetch_valid = 1'b1; fetch_addr = pc;
            #1;
            if (pc == wa) vis_a++;
            if (pc == wb) vis_b++;
            if (redirect_valid && stall) n_clash++;
            if (stall) n_stall++;
            if (redirect_valid) begin
                if (n_redir == 0) first_tgt = redirect_addr;
                n_redir++;
                pc = redirect_addr;
            end else if (!stall) begin
                pc = pc + 1;
            end
        end
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "redirect_valid", int'(redirect_valid), 0);
        check("R1", "stall", int'(stall), 0);
        check("R1", "in_loop", int'(in_loop), 0);
        check("R1", "level_active", int'(level_active), 0);
    endtask

    task automatic t_loads();
        cmd(3'd3, 24'h000014);
        cmd(3'd4, 24'h000018);
        #1 check("R2", "start/end do not arm", int'(level_active), 0);
        cmd(3'd7, 24'h000002);
        #1 check("R2", "opcode 7 no-op", int'(in_loop), 0);
        cmd(3'd0, 24'h000100);
        cmd(3'd1, 24'h000103);
        cmd(3'd2, 24'h000002);
        #1 check("R2", "count arms level 0", int'(level_active), 1);
        check("R11", "in_loop with level", int'(in_loop), 1);
    endtask

    task automatic t_simple_loop();
        // level 0 armed 0x100..0x103 count 2 by t_loads
        run_fetch(24'h000100, 24'h000104, 24'h000103, 24'h000100, 100);
        check("R3", "end visits", vis_a, 3);
        check("R3", "start visits", vis_b, 3);
        check("R3", "redirects", n_redir, 2);
        check("R3", "target", int'(first_tgt), 'h100);
        check("R4", "level 0 left", int'(level_active), 0);
        check("R11", "in_loop cleared", int'(in_loop), 0);
    endtask

    task automatic t_zero_count();
        cmd(3'd0, 24'h000090);
        cmd(3'd1, 24'h000091);
        cmd(3'd2, 24'h000000);
        run_fetch(24'h000090, 24'h000092, 24'h000091, 24'h000090, 20);
        check("R4", "single pass visits", vis_a, 1);
        check("R4", "no redirect", n_redir, 0);
        check("R4", "level exits", int'(level_active), 0);
    endtask

    task automatic t_mismatch();
        cmd(3'd0, 24'h000080);
        cmd(3'd1, 24'h000082);
        cmd(3'd2, 24'h000003);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 24'h000090;
        #1 check("R5", "no redirect off end", int'(redirect_valid), 0);
        @(negedge clk);
        fetch_valid = 1'b0;
        #1 check("R5", "level still active", int'(level_active), 1);
        do_flush();
    endtask

    task automatic t_invalid_fetch();
        cmd(3'd0, 24'h000070);
        cmd(3'd1, 24'h000072);
        cmd(3'd2, 24'h000001);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_addr = 24'h000072;
        #1 check("R12", "no redirect when invalid", int'(redirect_valid), 0);
        run_fetch(24'h000070, 24'h000073, 24'h000072, 24'h000070, 40);
        check("R12", "count untouched: end visits", vis_a, 2);
        check("R12", "count untouched: redirects", n_redir, 1);
    endtask

    task automatic t_nested();
        cmd(3'd0, 24'h000010);
        cmd(3'd1, 24'h000020);
        cmd(3'd2, 24'h000001);
        cmd(3'd3, 24'h000014);
        cmd(3'd4, 24'h000018);
        cmd(3'd5, 24'h000002);
        #1 check("R2", "both armed", int'(level_active), 3);
        run_fetch(24'h000010, 24'h000021, 24'h000018, 24'h000020, 200);
        check("R7", "inner end visits over two outer passes", vis_a, 6);
        check("R7", "outer end visits", vis_b, 2);
        check("R7", "redirects", n_redir, 5);
        check("R7", "both cleared", int'(level_active), 0);
    endtask

    task automatic t_shared_end();
        cmd(3'd0, 24'h000030);
        cmd(3'd1, 24'h000038);
        cmd(3'd2, 24'h000001);
        cmd(3'd3, 24'h000034);
        cmd(3'd4, 24'h000038);
        cmd(3'd5, 24'h000001);
        run_fetch(24'h000030, 24'h000039, 24'h000038, 24'h000034, 200);
        check("R6", "first target is inner start", int'(first_tgt), 'h34);
        check("R6", "shared end visits", vis_a, 4);
        check("R6", "inner start visits", vis_b, 4);
        check("R6", "redirects", n_redir, 3);
        check("R6", "levels cleared", int'(level_active), 0);
    endtask

    task automatic t_repeat();
        cmd(3'd6, 24'h000003);
        #1 check("R11", "in_loop with pending repeat", int'(in_loop), 1);
        run_fetch(24'h000040, 24'h000041, 24'h000040, 24'h000041, 20);
        check("R8", "issues for N=4", vis_a, 4);
        check("R8", "stall cycles", n_stall, 3);
        check("R11", "in_loop after repeat", int'(in_loop), 0);
        cmd(3'd6, 24'h000000);
        run_fetch(24'h000044, 24'h000045, 24'h000044, 24'h000045, 20);
        check("R8", "count 0 single issue", vis_a, 1);
        check("R8", "count 0 no stall", n_stall, 0);
    endtask

    task automatic t_repeat_at_end();
        cmd(3'd0, 24'h000052);
        cmd(3'd1, 24'h000052);
        cmd(3'd2, 24'h000001);
        cmd(3'd6, 24'h000002);
        run_fetch(24'h000052, 24'h000053, 24'h000052, 24'h000053, 40);
        check("R9", "issues of end instr", vis_a, 4);
        check("R9", "stall cycles", n_stall, 2);
        check("R9", "redirects", n_redir, 1);
        check("R9", "redirect with stall", n_clash, 0);
    endtask

    task automatic t_flush();
        cmd(3'd0, 24'h000060);
        cmd(3'd1, 24'h000060);
        cmd(3'd2, 24'h000004);
        cmd(3'd6, 24'h000003);
        @(negedge clk);
        flush = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd5; cmd_data = 24'h000005;
        @(negedge clk);
        flush = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd7;
        #1;
        check("R10", "levels cleared", int'(level_active), 0);
        check("R10", "in_loop cleared", int'(in_loop), 0);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 24'h000060;
        #1;
        check("R10", "no redirect after flush", int'(redirect_valid), 0);
        check("R10", "no stall after flush", int'(stall), 0);
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_loads();
        t_simple_loop();
        t_zero_count();
        t_mismatch();
        t_invalid_fetch();
        t_nested();
        t_shared_end();
        t_repeat();
        t_repeat_at_end();
        t_flush();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule